// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer Register

This block keeps the bus time of day for the link layer of a serial isochronous bus. It holds one 32-bit word that is split into three counter fields. The low field is the sub-cycle offset. It advances once for every pulse of a 24.576 MHz time-base tick. When the offset rolls over, the cycle number advances. When the cycle number rolls over, the seconds field advances. The 24.576 MHz rate reaches the block as a one-cycle enable pulse, so all of the logic runs on a single system clock.

Software reaches the word through a simple host register port at one fixed address. It can read the word there and overwrite it. A mode input comes from a bit held in a separate link control register. When that input is set, the word counts by itself. When it is clear, the word stands still and acts as a plain scratch register, which lets firmware test the host path with any pattern it likes.

Top module: `cyc_timer_reg`

## Requirements
- R1: After reset the whole timer word is 0x00000000, both on `cycle_time` and when read through the host port.
- R2: The fields sit at fixed positions in the word: offset in bits 11..0, cycle number in bits 24..12 and seconds in bits 31..25. While `count_en` is 1 and there is no host write, each cycle with `tick` = 1 raises the offset by one.
- R3: When a tick arrives while the offset is 3071, the offset returns to 0 and the cycle number rises by one.
- R4: When the offset wraps while the cycle number is 7999, the cycle number returns to 0 and the seconds field rises by one.
- R5: When the seconds field is 127 and a carry arrives from the cycle number, the seconds field returns to 0 and the word becomes 0x00000000.
- R6: While `count_en` is 0 the word does not change on ticks, and any written 32-bit value reads back bit for bit unchanged.
- R7: A host write takes the place of a tick in the same cycle. The word then equals the written data, and the next tick counts on from that value.
- R8: When `tick` is 0 and there is no write, the word keeps its value even if `count_en` is 1.
- R9: A write changes the word only when `host_addr` equals `TIMER_ADDR` (default 0x010). A read at any other address returns 0 on `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released in step with the clock |
| tick | input | 1 | One-cycle pulse at the 24.576 MHz time-base rate |
| count_en | input | 1 | Mode bit from the link control register: 1 = count, 0 = scratch register |
| host_addr | input | ADDR_W (12) | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Timer word when `host_addr` matches, otherwise 0 |
| cycle_time | output | 32 | Current timer word |

## Verification
A wrong field state shows at the ports on the first tick after it arises. A carry that is lost or arrives early leaves the cycle number or the seconds field wrong one cycle after the offset passes 3071. An address that is decoded wrongly shows at once, as nonzero read data or as a word that changes after a write to another address. The directed scenarios load values close to each wrap point. That lets every carry be seen within a few ticks, where waiting for it would take thousands of ticks.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int OFFSET_W    = 12;
  localparam int NUMBER_W    = 13;
  localparam int SECONDS_W   = 7;
  localparam int OFFSET_MOD  = 3072;
  localparam int NUMBER_MOD  = 8000;
  localparam int SECONDS_MOD = 128;
  localparam int WORD_W      = OFFSET_W + NUMBER_W + SECONDS_W;

  typedef struct packed {
    logic [SECONDS_W-1:0] seconds;
    logic [NUMBER_W-1:0]  number;
    logic [OFFSET_W-1:0]  offset;
  } cyc_time_t;

endpackage

// File: rtl/ctmr_rst_sync.sv
module ctmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ctmr_field.sv
module ctmr_field #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carry
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic         at_last;
  logic         upd;
  logic [W-1:0] value_nxt;

  generate
    if (MOD == (1 << W)) begin : g_natural
      assign at_last = &value;
    end else begin : g_modulo
      assign at_last = (value == LAST);
    end
  endgenerate

  always_comb begin
    carry     = inc && at_last && !load;
    upd       = load || inc;
    value_nxt = value;
    if (load)         value_nxt = load_val;
    else if (at_last) value_nxt = '0;
    else              value_nxt = value + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (upd) value <= value_nxt;
  end

endmodule

// File: rtl/ctmr_host.sv
module ctmr_host #(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] TIMER_ADDR = 12'h010
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] word,
  output logic              wr_hit,
  output logic [DATA_W-1:0] host_rdata
);

  logic sel;

  always_comb begin
    sel        = (host_addr == TIMER_ADDR);
    wr_hit     = sel && host_wr;
    host_rdata = sel ? word : '0;
  end

endmodule

// File: rtl/cyc_timer_reg.sv
module cyc_timer_reg
  import ctmr_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] TIMER_ADDR = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              count_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic [WORD_W-1:0] cycle_time
);

  logic      rst_n_sync;
  logic      wr_hit;
  logic      step;
  logic      off_carry;
  logic      num_carry;
  logic      sec_carry;
  cyc_time_t now_t;
  cyc_time_t wr_t;

  ctmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ctmr_host #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (WORD_W),
    .TIMER_ADDR (TIMER_ADDR)
  ) u_host (
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .word       (now_t),
    .wr_hit     (wr_hit),
    .host_rdata (host_rdata)
  );

  always_comb begin
    wr_t = cyc_time_t'(host_wdata);
    step = tick && count_en && !wr_hit;
  end

  ctmr_field #(.W(OFFSET_W), .MOD(OFFSET_MOD)) u_offset (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (wr_hit),
    .load_val (wr_t.offset),
    .inc      (step),
    .value    (now_t.offset),
    .carry    (off_carry)
  );

  ctmr_field #(.W(NUMBER_W), .MOD(NUMBER_MOD)) u_number (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (wr_hit),
    .load_val (wr_t.number),
    .inc      (off_carry),
    .value    (now_t.number),
    .carry    (num_carry)
  );

  ctmr_field #(.W(SECONDS_W), .MOD(SECONDS_MOD)) u_seconds (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (wr_hit),
    .load_val (wr_t.seconds),
    .inc      (num_carry),
    .value    (now_t.seconds),
    .carry    (sec_carry)
  );

  assign cycle_time = now_t;

  logic unused_ok;
  assign unused_ok = sec_carry;

endmodule

// File: rtl/cyc_timer_reg_chk.sv
module cyc_timer_reg_chk
  import ctmr_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] TIMER_ADDR = 12'h010
) (
  input logic              clk,
  input logic              rst_q,
  input logic              tick,
  input logic              count_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [WORD_W-1:0] host_wdata,
  input logic [WORD_W-1:0] host_rdata,
  input logic [WORD_W-1:0] cycle_time
);

  logic      wr_at;
  cyc_time_t t;
  assign wr_at = host_wr && (host_addr == TIMER_ADDR);
  assign t     = cyc_time_t'(cycle_time);

  // R2
  offset_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && count_en && !wr_at && t.offset != 12'd3071)
    |=> (t.offset == 12'($past(t.offset) + 12'd1)) && (t.number == $past(t.number)));

  // R3
  offset_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && count_en && !wr_at && t.offset == 12'd3071 && t.number != 13'd7999)
    |=> (t.offset == 12'd0) && (t.number == 13'($past(t.number) + 13'd1)));

  // R4
  number_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && count_en && !wr_at && t.offset == 12'd3071 && t.number == 13'd7999)
    |=> (t.number == 13'd0) && (t.seconds == 7'($past(t.seconds) + 7'd1)));

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!count_en && !wr_at) |=> $stable(cycle_time));

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wr_at |=> (cycle_time == $past(host_wdata)));

  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!tick && !wr_at) |=> $stable(cycle_time));

  // R9
  read_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_addr != TIMER_ADDR) |-> (host_rdata == '0));

endmodule

bind cyc_timer_reg cyc_timer_reg_chk #(
  .ADDR_W     (ADDR_W),
  .TIMER_ADDR (TIMER_ADDR)
) u_chk (
  .clk        (clk),
  .rst_q      (rst_n_sync),
  .tick       (tick),
  .count_en   (count_en),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .cycle_time (cycle_time)
);

// File: tb/cyc_timer_reg_test.sv
module cyc_timer_reg_test;

  localparam int         CLK_PERIOD = 10;
  localparam logic [11:0] T_ADDR    = 12'h010;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        count_en;
  logic [11:0] host_addr;
  logic        host_wr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [31:0] cycle_time;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_timer_reg uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .count_en   (count_en),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cycle_time (cycle_time)
  );

  function automatic logic [31:0] pack(int s, int n, int o);
    return {7'(s), 13'(n), 12'(o)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [11:0] a, logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_addr = T_ADDR;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic read_chk(string req, logic [31:0] exp);
    host_addr = T_ADDR;
    #1;
    chk(req, host_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 reset word", cycle_time, 32'h0);
    read_chk("R1 reset read", 32'h0);
  endtask

  task automatic t_scratch;
    count_en = 1'b0;
    host_write(T_ADDR, 32'hDEADBEEF);
    read_chk("R6 scratch readback", 32'hDEADBEEF);
    ticks(4);
    read_chk("R6 hold on ticks while disabled", 32'hDEADBEEF);
    host_write(T_ADDR, 32'h5A5A_F0F0);
    read_chk("R6 second pattern", 32'h5A5A_F0F0);
  endtask

  task automatic t_step;
    count_en = 1'b1;
    host_write(T_ADDR, pack(3, 100, 0));
    ticks(5);
    read_chk("R2 offset +5", pack(3, 100, 5));
  endtask

  task automatic t_no_tick;
    repeat (6) @(negedge clk);
    read_chk("R8 no tick hold", pack(3, 100, 5));
  endtask

  task automatic t_offset_wrap;
    host_write(T_ADDR, pack(0, 41, 3070));
    ticks(1);
    read_chk("R3 offset at last", pack(0, 41, 3071));
    ticks(1);
    read_chk("R3 offset wrap", pack(0, 42, 0));
  endtask

  task automatic t_number_wrap;
    host_write(T_ADDR, pack(5, 7999, 3071));
    ticks(1);
    read_chk("R4 number wrap", pack(6, 0, 0));
  endtask

  task automatic t_seconds_wrap;
    host_write(T_ADDR, pack(127, 7999, 3071));
    ticks(1);
    read_chk("R5 seconds wrap", 32'h0);
  endtask

  task automatic t_write_priority;
    host_addr = T_ADDR; host_wdata = pack(9, 9, 9);
    host_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; tick = 1'b0;
    read_chk("R7 write beats tick", pack(9, 9, 9));
    ticks(1);
    read_chk("R7 count from written", pack(9, 9, 10));
  endtask

  task automatic t_address;
    host_write(12'h014, 32'h1234_5678);
    read_chk("R9 other address write ignored", pack(9, 9, 10));
    host_addr = 12'h00C;
    #1;
    chk("R9 read miss zero", host_rdata, 32'h0);
    chk("R9 word unchanged", cycle_time, pack(9, 9, 10));
    host_addr = T_ADDR;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; count_en = 1'b0;
    host_addr = T_ADDR; host_wr = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_scratch;
    t_step;
    t_no_tick;
    t_offset_wrap;
    t_number_wrap;
    t_seconds_wrap;
    t_write_priority;
    t_address;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule